// File: doc/BRIEF.md
# Coincidence Gate Controller

This controller sits between the digital compare outputs of a particle detector front end and its ADC sequencer. When the main channel reports an event, the controller decides whether the event is kept. If it is kept, the controller sends a one-cycle conversion request. If it is dropped, the controller sends a one-cycle peak-hold reset and adds one to a saturating rejection counter.

The decision uses a gate signal. The gate comes either from the internal coincidence comparator or from an external pin. The external pin passes through a synchronizer first. The controller watches the gate over a programmable window of clock edges. In coincidence gating, the gate must be seen during the window. In anti-coincidence gating, the gate must stay absent for the whole window. With the coincidence channel disabled, every event is kept at once.

The flow is driven only by events. The window counter and gate tracker stay still until an event arrives. Power enables turn off the blocks that the current configuration does not use. A quiet setting turns all of them off and ignores events.

Top module: `cgate_ctrl`

## Requirements
- R1: After reset, conv_req, pk_reset and busy are 0, and rej_count is 0.
- R2: When cfg_coin_en is 0, an event detected in idle (main_evt high on a clock edge) produces conv_req high for exactly one cycle, starting right after that edge. In this mode pk_reset never rises.
- R3: When cfg_coin_en is 1 and cfg_anti is 0, the event is accepted only if the selected gate is 1 on at least one of the N edges that follow the detecting edge. Otherwise it is rejected. The verdict appears for one cycle right after the Nth of those edges.
- R4: When cfg_coin_en is 1 and cfg_anti is 1, the event is accepted only if the selected gate is 0 on all N sampling edges. Otherwise it is rejected. The verdict has the same timing as in R3.
- R5: cfg_ext_sel=0 selects coin_int as the gate, and coin_ext then has no effect. cfg_ext_sel=1 selects coin_ext, taken through SYNC_STAGES flip-flops, and coin_int then has no effect.
- R6: N equals cfg_window, except that cfg_window=0 gives N=1. A gate level on the detecting edge itself is not counted. A gate level on the Nth edge after it is counted.
- R7: A rejection raises pk_reset for one cycle. One edge later, rej_count goes up by 1, but it stays at 2^CNT_W-1 once it reaches that value. conv_req and pk_reset are never high together.
- R8: busy is 1 from the detecting edge until main_evt is seen low after the verdict. Over that span no second verdict is produced, even if main_evt stays high.
- R9: When cfg_quiet is 1, pwr_main, pwr_coin and pwr_adc are all 0, and an event arriving in idle is ignored: busy stays 0 and no verdict appears.
- R10: When cfg_quiet is 0, pwr_main and pwr_adc are 1, and pwr_coin is 1 only when cfg_coin_en is 1 and cfg_ext_sel is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| main_evt | input | 1 | Main-channel event detect (peak latched) |
| coin_int | input | 1 | Internal coincidence comparator output |
| coin_ext | input | 1 | External coincidence pin, asynchronous |
| cfg_coin_en | input | 1 | Coincidence channel enable |
| cfg_anti | input | 1 | 1 selects anti-coincidence gating |
| cfg_ext_sel | input | 1 | 1 selects the external gate source |
| cfg_quiet | input | 1 | Quiet mode: power everything down, ignore events |
| cfg_window | input | WIN_W | Window length N in edges (0 means 1) |
| conv_req | output | 1 | One-cycle conversion request |
| pk_reset | output | 1 | One-cycle peak-hold reset on rejection |
| busy | output | 1 | Event in progress |
| rej_count | output | CNT_W | Saturating rejection counter |
| pwr_main | output | 1 | Main channel power enable |
| pwr_coin | output | 1 | Internal coincidence channel power enable |
| pwr_adc | output | 1 | ADC power enable |

## Verification
The hardest cases to reach are the window edges. A gate pulse that lands exactly on the last sampling edge must count. A gate level present on the detecting edge must not. To hit them, the stimulus changes inputs on falling edges, with a per-edge gate pattern lined up to the cycle that the event is first seen. The rejection counter's saturation point is reached by a long run of one-edge windows that force rejections. Re-arming is tested by holding main_evt high well past the verdict.

// File: rtl/cgate_pkg.sv
package cgate_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_WIN  = 2'd1,
      ST_REL  = 2'd2
   } cg_state_e;
endpackage

// File: rtl/cgate_sync.sv
module cgate_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);
   generate
      if (STAGES == 0) begin : g_bypass
         assign dout = din;
      end else begin : g_chain
         logic [STAGES-1:0] chain;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= '0;
            else        chain <= {chain[STAGES-2+((STAGES==1)?1:0):0], din};
         end
         assign dout = chain[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/cgate_rejcnt.sv
module cgate_rejcnt #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             inc,
   output logic [CNT_W-1:0] cnt
);
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     cnt <= '0;
      else if (inc && cnt != CNT_MAX) cnt <= cnt + 1'b1;
   end

   AST_SAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt == CNT_MAX) |=> (cnt == CNT_MAX)); // R7
   AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(inc) && $past(cnt) != CNT_MAX) |-> (cnt == $past(cnt) + 1'b1)); // R7
endmodule

// File: rtl/cgate_power.sv
module cgate_power (
   input  logic quiet,
   input  logic coin_en,
   input  logic ext_sel,
   output logic pwr_main,
   output logic pwr_coin,
   output logic pwr_adc
);
   always_comb begin
      pwr_main = !quiet;
      pwr_adc  = !quiet;
      pwr_coin = !quiet && coin_en && !ext_sel;
   end
endmodule

// File: rtl/cgate_ctrl.sv
module cgate_ctrl
   import cgate_pkg::*;
#(
   parameter int WIN_W       = 4,
   parameter int CNT_W       = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             main_evt,
   input  logic             coin_int,
   input  logic             coin_ext,
   input  logic             cfg_coin_en,
   input  logic             cfg_anti,
   input  logic             cfg_ext_sel,
   input  logic             cfg_quiet,
   input  logic [WIN_W-1:0] cfg_window,
   output logic             conv_req,
   output logic             pk_reset,
   output logic             busy,
   output logic [CNT_W-1:0] rej_count,
   output logic             pwr_main,
   output logic             pwr_coin,
   output logic             pwr_adc
);
   generate
      if (WIN_W < 1 || CNT_W < 1 || SYNC_STAGES < 0) begin : g_bad_param
         $error("cgate_ctrl: WIN_W and CNT_W must be >= 1, SYNC_STAGES >= 0");
      end
   endgenerate

   logic             ext_sync;
   logic             gate;
   logic             hit;
   logic             seen_q;
   logic [WIN_W-1:0] win_cnt;
   logic [WIN_W-1:0] win_last;
   cg_state_e        state;

   cgate_sync #(.STAGES(SYNC_STAGES)) i_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (coin_ext),
      .dout (ext_sync)
   );

   assign gate     = cfg_ext_sel ? ext_sync : coin_int;
   assign hit      = seen_q | gate;
   assign win_last = (cfg_window == '0) ? '0 : cfg_window - 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         win_cnt  <= '0;
         seen_q   <= 1'b0;
         conv_req <= 1'b0;
         pk_reset <= 1'b0;
      end else begin
         conv_req <= 1'b0;
         pk_reset <= 1'b0;
         unique case (state)
            ST_IDLE: begin
               if (main_evt && !cfg_quiet) begin
                  if (!cfg_coin_en) begin
                     conv_req <= 1'b1;
                     state    <= ST_REL;
                  end else begin
                     win_cnt <= '0;
                     seen_q  <= 1'b0;
                     state   <= ST_WIN;
                  end
               end
            end
            ST_WIN: begin
               if (win_cnt == win_last) begin
                  conv_req <= cfg_anti ? !hit : hit;
                  pk_reset <= cfg_anti ? hit : !hit;
                  state    <= ST_REL;
               end else begin
                  win_cnt <= win_cnt + 1'b1;
                  seen_q  <= hit;
               end
            end
            ST_REL: begin
               if (!main_evt) state <= ST_IDLE;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign busy = (state != ST_IDLE);

   cgate_rejcnt #(.CNT_W(CNT_W)) i_rejcnt (
      .clk  (clk),
      .rst_n(rst_n),
      .inc  (pk_reset),
      .cnt  (rej_count)
   );

   cgate_power i_power (
      .quiet   (cfg_quiet),
      .coin_en (cfg_coin_en),
      .ext_sel (cfg_ext_sel),
      .pwr_main(pwr_main),
      .pwr_coin(pwr_coin),
      .pwr_adc (pwr_adc)
   );

   AST_ONE_VERDICT: assert property (@(posedge clk) disable iff (!rst_n)
      !(conv_req && pk_reset)); // R7
   AST_VERDICT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      (conv_req || pk_reset) |=> !(conv_req || pk_reset)); // R8
   AST_NO_REJECT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      pk_reset |-> $past(cfg_coin_en)); // R2
   AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_quiet && !busy) |=> !busy); // R9
   AST_VERDICT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (conv_req || pk_reset) |-> busy); // R8
endmodule

// File: tb/test_cgate_ctrl.sv
`timescale 1ns/1ps
module test_cgate_ctrl;
   localparam int WIN_W = 4;
   localparam int CNT_W = 8;
   localparam int SYNC  = 2;
   localparam int CMAX  = (1 << CNT_W) - 1;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             main_evt = 1'b0, coin_int = 1'b0, coin_ext = 1'b0;
   logic             cfg_coin_en = 1'b0, cfg_anti = 1'b0, cfg_ext_sel = 1'b0, cfg_quiet = 1'b0;
   logic [WIN_W-1:0] cfg_window = '0;
   logic             conv_req, pk_reset, busy, pwr_main, pwr_coin, pwr_adc;
   logic [CNT_W-1:0] rej_count;

   int  n_tests = 0;
   int  n_fail  = 0;
   int  rej_model = 0;
   bit  done = 1'b0;
   bit  exp_q[$];

   always #2.5 clk = ~clk;

   cgate_ctrl #(.WIN_W(WIN_W), .CNT_W(CNT_W), .SYNC_STAGES(SYNC)) i_cgate_ctrl (
      .clk(clk), .rst_n(rst_n), .main_evt(main_evt), .coin_int(coin_int),
      .coin_ext(coin_ext), .cfg_coin_en(cfg_coin_en), .cfg_anti(cfg_anti),
      .cfg_ext_sel(cfg_ext_sel), .cfg_quiet(cfg_quiet), .cfg_window(cfg_window),
      .conv_req(conv_req), .pk_reset(pk_reset), .busy(busy), .rej_count(rej_count),
      .pwr_main(pwr_main), .pwr_coin(pwr_coin), .pwr_adc(pwr_adc)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // Monitor: pops the expected verdict (1 = accept) for each verdict pulse seen
   always @(negedge clk) begin
      if (rst_n && (conv_req || pk_reset)) begin
         if (conv_req && pk_reset) chk("R7 both verdicts", 1, 0);
         else if (exp_q.size() == 0) chk("R8 unexpected verdict", int'(conv_req), 2);
         else chk("R3/R4 scoreboard verdict", int'(conv_req), int'(exp_q.pop_front()));
      end
   end

   // Event through the gate window; pat bit i is the gate on sampling edge i+1
   task automatic gated_event(input bit pre, input logic [15:0] pat, input int n,
                              input bit acc, input string req);
      exp_q.push_back(acc);
      @(negedge clk);
      main_evt = 1'b1;
      coin_int = pre;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         if (i == n - 1) chk({req, " no early verdict"}, int'(conv_req | pk_reset), 0);
         coin_int = pat[i];
      end
      @(negedge clk);
      chk({req, " verdict timing"}, int'(acc ? conv_req : pk_reset), 1);
      coin_int = 1'b0;
      main_evt = 1'b0;
      if (!acc && rej_model < CMAX) rej_model++;
      repeat (2) @(negedge clk);
      chk({req, " idle again"}, int'(busy), 0);
      chk("R7 rej_count", int'(rej_count), rej_model);
   endtask

   task automatic direct_event();
      exp_q.push_back(1'b1);
      @(negedge clk);
      main_evt = 1'b1;
      coin_int = 1'b0;
      @(negedge clk);
      chk("R2 immediate accept", int'(conv_req), 1);
      main_evt = 1'b0;
      @(negedge clk);
      chk("R2 single pulse", int'(conv_req), 0);
      @(negedge clk);
   endtask

   task automatic cfg(input bit en, input bit anti, input bit ext, input int win);
      @(negedge clk);
      cfg_coin_en = en; cfg_anti = anti; cfg_ext_sel = ext;
      cfg_window = WIN_W'(win);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 conv_req", int'(conv_req), 0);
      chk("R1 pk_reset", int'(pk_reset), 0);
      chk("R1 busy", int'(busy), 0);
      chk("R1 rej_count", int'(rej_count), 0);

      // R10 power enables
      cfg(1, 0, 0, 3); #1;
      chk("R10 pwr_coin internal", int'(pwr_coin), 1);
      chk("R10 pwr_main", int'(pwr_main), 1);
      chk("R10 pwr_adc", int'(pwr_adc), 1);
      cfg(1, 0, 1, 3); #1;
      chk("R10 pwr_coin external", int'(pwr_coin), 0);
      cfg(0, 0, 0, 3); #1;
      chk("R10 pwr_coin disabled", int'(pwr_coin), 0);

      // R2 channel disabled
      direct_event();
      coin_int = 1'b1;
      direct_event();

      // R3 coincidence
      cfg(1, 0, 0, 3);
      gated_event(0, 16'b010, 3, 1, "R3 gate mid");
      gated_event(0, 16'b000, 3, 0, "R3 no gate");
      // R4 anti-coincidence
      cfg(1, 1, 0, 3);
      gated_event(0, 16'b000, 3, 1, "R4 quiet gate");
      gated_event(0, 16'b100, 3, 0, "R4 gate last");
      // R6 window edges
      cfg(1, 0, 0, 4);
      gated_event(0, 16'b1000, 4, 1, "R6 gate on Nth edge");
      gated_event(1, 16'b0000, 4, 0, "R6 gate on detect edge");
      cfg(1, 0, 0, 0);
      gated_event(0, 16'b1, 1, 1, "R6 zero window accept");
      gated_event(0, 16'b0, 1, 0, "R6 zero window reject");

      // R5 source select
      cfg(1, 0, 1, 3);
      coin_ext = 1'b1;
      repeat (SYNC + 2) @(negedge clk);
      gated_event(0, 16'b000, 3, 1, "R5 external gate");
      coin_ext = 1'b0;
      repeat (SYNC + 2) @(negedge clk);
      gated_event(0, 16'b111, 3, 0, "R5 internal ignored");
      cfg(1, 0, 0, 3);
      coin_ext = 1'b1;
      gated_event(0, 16'b000, 3, 0, "R5 external ignored");
      coin_ext = 1'b0;

      // R8 re-arm: hold main_evt long after the verdict
      cfg(0, 0, 0, 1);
      exp_q.push_back(1'b1);
      @(negedge clk); main_evt = 1'b1;
      repeat (6) @(negedge clk);
      chk("R8 busy while held", int'(busy), 1);
      chk("R8 single verdict", exp_q.size(), 0);
      main_evt = 1'b0;
      @(negedge clk);
      chk("R8 re-armed", int'(busy), 0);

      // R9 quiet
      @(negedge clk); cfg_quiet = 1'b1; #1;
      chk("R9 pwr_main", int'(pwr_main), 0);
      chk("R9 pwr_adc", int'(pwr_adc), 0);
      chk("R9 pwr_coin", int'(pwr_coin), 0);
      @(negedge clk); main_evt = 1'b1;
      repeat (4) @(negedge clk);
      chk("R9 event ignored", int'(busy), 0);
      main_evt = 1'b0;
      @(negedge clk); cfg_quiet = 1'b0;

      // R7 saturation
      cfg(1, 0, 0, 1);
      for (int k = 0; k < CMAX + 4; k++) gated_event(0, 16'b0, 1, 0, "R7 reject run");
      chk("R7 saturated", int'(rej_count), CMAX);
      chk("R3 queue drained", exp_q.size(), 0);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      #(200000 * 5);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end
endmodule